// File: doc/BRIEF.md
# Source-Routed Packet Sender with Negative-Acknowledge Restart

This block is the transmit engine of a board's network interface into a self-routing switch fabric built from 2x2 elements. Outgoing messages are pushed one lane word at a time into an internal queue. The message at the head of that queue is sent as a packet. A packet has three parts: a presence flag that is high for the whole emission, a route field with one steering bit for each fabric stage, and a payload that is striped over parallel lanes, one lane word per cycle.

When the fabric drops a packet because of contention, it reflects a negative acknowledge (NACK) back to the sender. The engine then abandons the current emission and starts the same packet again from its first word in the next cycle. A packet is removed from the queue only when its emission ends without a NACK. Messages shorter than the fabric's minimum packet length are padded with zero words. Because of this minimum length, a NACK always arrives while the sender is still transmitting. A retry count for the packet at the head of the queue is made visible as status.

The block also contains a separate receive-side reassembler. It takes lane words from the fabric and packs them into wider words. It flags the last word of each packet and hands the words on.

Top module: `srs_top`

## Requirements
- R1: Packets are emitted in the order their messages were pushed, and each packet's lane words appear on `tx_lanes` in push order, one word per cycle while `tx_valid` is high.
- R2: `tx_route` holds the STAGES-bit route of the packet being sent for every cycle of its emission. The route is the value on `push_route` in the cycle of the message's final word (`push_last`=1). `tx_route` is zero while `tx_valid` is low.
- R3: `tx_valid` stays high for the whole emission and goes low for at least one cycle after every successful emission.
- R4: An emission lasts max(L, MIN_WORDS) cycles for a message of L words. Word positions at or beyond L are driven as zero.
- R5: A NACK in any cycle of an emission makes the next cycle emit word 0 of the same packet again.
- R6: A packet leaves the queue only after its final word is sent in a cycle with `nack` low. A NACK on the final word restarts the packet.
- R7: A NACK while `tx_valid` is low has no effect on the queue, on `tx_valid` or on `retry_cnt`.
- R8: `retry_cnt` increases by one for each NACK during an emission. It saturates at 2^RETRY_W-1 and returns to 0 after the packet completes.
- R9: `push_ready` is low when all WDEPTH word slots or all DDEPTH message slots are occupied. A push while `push_ready` is low stores nothing.
- R10: The reassembler places the k-th lane word of a packet at bits [(k mod PACK)*LANES +: LANES] of an output word and outputs a word after every PACK lane words. The final word of a packet is zero-filled above the last lane word and has `rx_word_last`=1. `rx_word_route` carries the route that arrived with the packet's words.
- R11: After reset, `tx_valid`, `retry_cnt` and `rx_word_valid` are 0 and `push_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | A lane word is offered to the queue |
| push_ready | output | 1 | The queue can take a word |
| push_data | input | LANES | Lane word being pushed |
| push_last | input | 1 | Marks the final word of a message |
| push_route | input | STAGES | Route of the message, taken with the final word |
| tx_valid | output | 1 | Packet presence |
| tx_route | output | STAGES | Per-stage steering bits of the packet in flight |
| tx_lanes | output | LANES | Payload lane word of this cycle |
| nack | input | 1 | Negative acknowledge from the fabric |
| retry_cnt | output | RETRY_W | Restarts of the current packet |
| rx_valid | input | 1 | Presence of a packet arriving from the fabric |
| rx_route | input | STAGES | Route bits arriving with the packet |
| rx_lanes | input | LANES | Arriving lane word |
| rx_word_valid | output | 1 | A reassembled word is presented |
| rx_word | output | PACK*LANES | Reassembled word |
| rx_word_last | output | 1 | Final word of a received packet |
| rx_word_route | output | STAGES | Route that came with the word |

## Verification
Two situations are hard to reach from the ports: a full queue, and the retry counter reaching its ceiling. While the head packet is being sent, the queue keeps draining itself. The stimulus therefore holds `nack` high during pushes so that nothing can leave the queue. In one phase it fills the message slots with one-word messages. In another it fills the word slots with two long messages. In each phase it then offers a push that must be refused. A continuous NACK lasting more than 2^RETRY_W cycles drives `retry_cnt` to saturation. Separate single-cycle NACKs are aimed at the middle word and at the final word of an emission, to show that the packet restarts and is not removed from the queue.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [0:0] {
    S_IDLE = 1'b0,
    S_SEND = 1'b1
  } tx_state_e;

endpackage

// File: rtl/srs_rst_sync.sv
module srs_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/srs_msg_store.sv
module srs_msg_store #(
  parameter int LANES  = 16,
  parameter int STAGES = 5,
  parameter int WDEPTH = 16,
  parameter int DDEPTH = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_data,
  input  logic              wr_last,
  input  logic [STAGES-1:0] wr_route,
  input  logic              pop,
  input  logic [CNT_W-1:0]  rd_idx,
  output logic              ready,
  output logic              has_pkt,
  output logic [CNT_W-1:0]  head_len,
  output logic [STAGES-1:0] head_route,
  output logic [LANES-1:0]  rd_word
);

  localparam int AW  = (WDEPTH > 1) ? $clog2(WDEPTH) : 1;
  localparam int DAW = (DDEPTH > 1) ? $clog2(DDEPTH) : 1;
  localparam int UW  = $clog2(WDEPTH + 1);
  localparam int DCW = $clog2(DDEPTH + 1);

  logic [LANES-1:0]  mem    [WDEPTH];
  logic [CNT_W-1:0]  dlen   [DDEPTH];
  logic [STAGES-1:0] droute [DDEPTH];

  logic [AW-1:0]    wp_q, wp_d, hp_q, hp_d;
  logic [UW-1:0]    used_q, used_d;
  logic [CNT_W-1:0] cur_q, cur_d;
  logic [DAW-1:0]   dw_q, dw_d, dr_q, dr_d;
  logic [DCW-1:0]   dc_q, dc_d;
  logic             msg_end;

  assign msg_end = wr_en && wr_last;

  always_comb begin
    wp_d   = wr_en ? wp_q + AW'(1) : wp_q;
    cur_d  = wr_en ? (wr_last ? '0 : cur_q + CNT_W'(1)) : cur_q;
    hp_d   = pop ? hp_q + AW'(head_len) : hp_q;
    used_d = used_q + UW'(wr_en) - (pop ? UW'(head_len) : '0);
    dw_d   = msg_end ? dw_q + DAW'(1) : dw_q;
    dr_d   = pop ? dr_q + DAW'(1) : dr_q;
    dc_d   = dc_q + DCW'(msg_end) - DCW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      hp_q   <= '0;
      used_q <= '0;
      cur_q  <= '0;
      dw_q   <= '0;
      dr_q   <= '0;
      dc_q   <= '0;
    end else if (wr_en || pop) begin
      wp_q   <= wp_d;
      hp_q   <= hp_d;
      used_q <= used_d;
      cur_q  <= cur_d;
      dw_q   <= dw_d;
      dr_q   <= dr_d;
      dc_q   <= dc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
    if (msg_end) begin
      dlen[dw_q]   <= cur_q + CNT_W'(1);
      droute[dw_q] <= wr_route;
    end
  end

  assign ready      = (used_q < UW'(WDEPTH)) && (dc_q < DCW'(DDEPTH));
  assign has_pkt    = (dc_q != '0);
  assign head_len   = dlen[dr_q];
  assign head_route = droute[dr_q];
  assign rd_word    = mem[hp_q + AW'(rd_idx)];

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (used_q < UW'(WDEPTH)));

  // R6
  pop_has_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (dc_q != '0));

endmodule

// File: rtl/srs_tx_ctrl.sv
module srs_tx_ctrl
  import srs_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int MIN_WORDS = 4,
  parameter int RETRY_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               has_pkt,
  input  logic [CNT_W-1:0]   head_len,
  input  logic               nack,
  output logic               busy,
  output logic [CNT_W-1:0]   idx,
  output logic               pop,
  output logic [RETRY_W-1:0] retry_cnt
);

  localparam logic [CNT_W-1:0] MINW = CNT_W'(MIN_WORDS);

  tx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   idx_q, idx_d;
  logic [RETRY_W-1:0] rty_q, rty_d;
  logic [CNT_W-1:0]   plen;
  logic               last_word;
  logic               en;

  assign plen      = (head_len < MINW) ? MINW : head_len;
  assign last_word = (idx_q == plen - CNT_W'(1));
  assign en        = (st_q == S_SEND) || has_pkt;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    rty_d = rty_q;
    pop   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (has_pkt) begin
          st_d  = S_SEND;
          idx_d = '0;
        end
      end
      S_SEND: begin
        if (nack) begin
          idx_d = '0;
          if (rty_q != '1) rty_d = rty_q + RETRY_W'(1);
        end else if (last_word) begin
          pop   = 1'b1;
          st_d  = S_IDLE;
          idx_d = '0;
          rty_d = '0;
        end else begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      rty_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      rty_q <= rty_d;
    end
  end

  assign busy      = (st_q == S_SEND);
  assign idx       = idx_q;
  assign retry_cnt = rty_q;

  // R5
  nack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SEND && nack) |=> (st_q == S_SEND && idx_q == '0));

  // R7
  idle_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && nack) |=> (rty_q == $past(rty_q)));

  // R8
  retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SEND && nack && rty_q != '1) |=> (rty_q == $past(rty_q) + RETRY_W'(1)));

  // R3
  gap_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (st_q == S_IDLE));

endmodule

// File: rtl/srs_rx_pack.sv
module srs_rx_pack #(
  parameter int LANES  = 16,
  parameter int STAGES = 5,
  parameter int PACK   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [STAGES-1:0]       rx_route,
  input  logic [LANES-1:0]        rx_lanes,
  output logic                    out_valid,
  output logic [PACK*LANES-1:0]   out_word,
  output logic                    out_last,
  output logic [STAGES-1:0]       out_route
);

  localparam int PW = (PACK > 1) ? $clog2(PACK) : 1;
  localparam int OW = PACK * LANES;

  logic              s_valid_q;
  logic [LANES-1:0]  s_word_q;
  logic [STAGES-1:0] s_route_q;
  logic [PW-1:0]     cnt_q, cnt_d;
  logic [OW-1:0]     acc_q, acc_d, merged;
  logic              ov_q, ov_d, ol_q, ol_d;
  logic [OW-1:0]     ow_q, ow_d;
  logic [STAGES-1:0] or_q, or_d;
  logic              s_last;

  assign s_last = s_valid_q && !rx_valid;

  always_comb begin
    merged = acc_q;
    merged[cnt_q*LANES +: LANES] = s_word_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    ov_d  = 1'b0;
    ol_d  = 1'b0;
    ow_d  = ow_q;
    or_d  = or_q;
    if (s_valid_q) begin
      if (cnt_q == PW'(PACK - 1) || s_last) begin
        ov_d  = 1'b1;
        ol_d  = s_last;
        ow_d  = merged;
        or_d  = s_route_q;
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = merged;
        cnt_d = cnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid_q <= 1'b0;
      s_word_q  <= '0;
      s_route_q <= '0;
      cnt_q     <= '0;
      acc_q     <= '0;
      ov_q      <= 1'b0;
      ol_q      <= 1'b0;
      ow_q      <= '0;
      or_q      <= '0;
    end else begin
      s_valid_q <= rx_valid;
      if (rx_valid) begin
        s_word_q  <= rx_lanes;
        s_route_q <= rx_route;
      end
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      ov_q  <= ov_d;
      ol_q  <= ol_d;
      ow_q  <= ow_d;
      or_q  <= or_d;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign out_last  = ol_q;
  assign out_route = or_q;

  // R10
  rx_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_q && !rx_valid) |=> (out_valid && out_last));

endmodule

// File: rtl/srs_top.sv
module srs_top #(
  parameter int LANES     = 16,
  parameter int STAGES    = 5,
  parameter int WDEPTH    = 16,
  parameter int DDEPTH    = 4,
  parameter int MIN_WORDS = 4,
  parameter int RETRY_W   = 4,
  parameter int PACK      = 2
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  push_valid,
  output logic                  push_ready,
  input  logic [LANES-1:0]      push_data,
  input  logic                  push_last,
  input  logic [STAGES-1:0]     push_route,
  output logic                  tx_valid,
  output logic [STAGES-1:0]     tx_route,
  output logic [LANES-1:0]      tx_lanes,
  input  logic                  nack,
  output logic [RETRY_W-1:0]    retry_cnt,
  input  logic                  rx_valid,
  input  logic [STAGES-1:0]     rx_route,
  input  logic [LANES-1:0]      rx_lanes,
  output logic                  rx_word_valid,
  output logic [PACK*LANES-1:0] rx_word,
  output logic                  rx_word_last,
  output logic [STAGES-1:0]     rx_word_route
);

  localparam int MAXP  = (WDEPTH > MIN_WORDS) ? WDEPTH : MIN_WORDS;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic              rst_n;
  logic              wr_en, pop, has_pkt, busy;
  logic [CNT_W-1:0]  head_len, idx;
  logic [STAGES-1:0] head_route;
  logic [LANES-1:0]  rd_word;

  srs_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign wr_en = push_valid && push_ready;

  srs_msg_store #(
    .LANES (LANES), .STAGES (STAGES), .WDEPTH (WDEPTH),
    .DDEPTH(DDEPTH), .CNT_W (CNT_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (push_data),
    .wr_last    (push_last),
    .wr_route   (push_route),
    .pop        (pop),
    .rd_idx     (idx),
    .ready      (push_ready),
    .has_pkt    (has_pkt),
    .head_len   (head_len),
    .head_route (head_route),
    .rd_word    (rd_word)
  );

  srs_tx_ctrl #(
    .CNT_W (CNT_W), .MIN_WORDS (MIN_WORDS), .RETRY_W (RETRY_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .has_pkt   (has_pkt),
    .head_len  (head_len),
    .nack      (nack),
    .busy      (busy),
    .idx       (idx),
    .pop       (pop),
    .retry_cnt (retry_cnt)
  );

  assign tx_valid = busy;
  assign tx_route = busy ? head_route : '0;
  assign tx_lanes = (busy && (idx < head_len)) ? rd_word : '0;

  srs_rx_pack #(
    .LANES (LANES), .STAGES (STAGES), .PACK (PACK)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_route  (rx_route),
    .rx_lanes  (rx_lanes),
    .out_valid (rx_word_valid),
    .out_word  (rx_word),
    .out_last  (rx_word_last),
    .out_route (rx_word_route)
  );

  // R6
  pop_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (tx_valid && !nack));

  // R2
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !pop) |=> (tx_valid && $stable(tx_route)));

endmodule

// File: tb/tb_srs_top.sv
module tb_srs_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16, STAGES = 5, WDEPTH = 16, DDEPTH = 4;
  localparam int MIN_WORDS = 4, RETRY_W = 4, PACK = 2;
  localparam int RMAX = (1 << RETRY_W) - 1;
  localparam int WD_CYC = 20000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic push_valid = 1'b0, push_last = 1'b0, nack = 1'b0, rx_valid = 1'b0;
  logic [LANES-1:0] push_data = '0, rx_lanes = '0;
  logic [STAGES-1:0] push_route = '0, rx_route = '0;
  logic push_ready, tx_valid, rx_word_valid, rx_word_last;
  logic [STAGES-1:0] tx_route, rx_word_route;
  logic [LANES-1:0] tx_lanes;
  logic [RETRY_W-1:0] retry_cnt;
  logic [PACK*LANES-1:0] rx_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  srs_top dut (
    .clk(clk), .rst_ni(rst_ni), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .push_last(push_last), .push_route(push_route),
    .tx_valid(tx_valid), .tx_route(tx_route), .tx_lanes(tx_lanes), .nack(nack),
    .retry_cnt(retry_cnt), .rx_valid(rx_valid), .rx_route(rx_route),
    .rx_lanes(rx_lanes), .rx_word_valid(rx_word_valid), .rx_word(rx_word),
    .rx_word_last(rx_word_last), .rx_word_route(rx_word_route)
  );

  int n_cmp = 0, n_bad = 0;
  string scen = "reset";

  // behavioural reference state
  logic [LANES-1:0]  wq[$];
  int                lq[$];
  logic [STAGES-1:0] rq[$];
  int pc = 0, idx = 0, rty = 0;
  bit busy = 0;
  logic [PACK*LANES-1:0] ewq[$];
  bit                    elq[$];
  logic [STAGES-1:0]     erq[$];

  function automatic int plen(int l);
    return (l < MIN_WORDS) ? MIN_WORDS : l;
  endfunction

  function automatic bit m_ready();
    return (wq.size() < WDEPTH) && (lq.size() < DDEPTH);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: actual %0h expected %0h", tag, scen, act, exp);
    end
  endtask

  task automatic model_edge();
    bit pushed;
    pushed = push_valid && m_ready();
    if (!busy) begin
      if (lq.size() > 0) begin busy = 1; idx = 0; end
    end else if (nack) begin
      idx = 0;
      if (rty < RMAX) rty++;
    end else if (idx == plen(lq[0]) - 1) begin
      for (int k = 0; k < lq[0]; k++) void'(wq.pop_front());
      void'(lq.pop_front());
      void'(rq.pop_front());
      busy = 0; idx = 0; rty = 0;
    end else begin
      idx++;
    end
    if (pushed) begin
      wq.push_back(push_data);
      pc++;
      if (push_last) begin
        lq.push_back(pc);
        rq.push_back(push_route);
        pc = 0;
      end
    end
  endtask

  task automatic compare();
    logic [LANES-1:0] el;
    el = (busy && idx < lq[0]) ? wq[idx] : '0;
    chk("R3 tx_valid", 64'(tx_valid), 64'(busy));
    chk("R2 tx_route", 64'(tx_route), busy ? 64'(rq[0]) : 64'd0);
    chk("R1 R4 tx_lanes", 64'(tx_lanes), 64'(el));
    chk("R8 retry_cnt", 64'(retry_cnt), 64'(rty));
    chk("R9 push_ready", 64'(push_ready), 64'(m_ready()));
    if (rx_word_valid) begin
      if (ewq.size() == 0) begin
        chk("R10 unexpected rx word", 64'(1), 64'(0));
      end else begin
        chk("R10 rx_word", 64'(rx_word), 64'(ewq.pop_front()));
        chk("R10 rx_word_last", 64'(rx_word_last), 64'(elq.pop_front()));
        chk("R10 rx_word_route", 64'(rx_word_route), 64'(erq.pop_front()));
      end
    end
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic push_msg(int len, logic [STAGES-1:0] rt, logic [LANES-1:0] base);
    for (int k = 0; k < len; k++) begin
      bit ok;
      do begin
        push_valid = 1; push_data = base + LANES'(k);
        push_last = (k == len - 1); push_route = rt;
        ok = m_ready();
        step();
      end while (!ok);
    end
    push_valid = 0; push_last = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((busy || lq.size() > 0) && guard < 500) begin step(); guard++; end
    step();
  endtask

  task automatic rx_packet(int n, logic [STAGES-1:0] rt, logic [LANES-1:0] base);
    logic [PACK*LANES-1:0] w = '0;
    for (int k = 0; k < n; k++) begin
      w[(k % PACK)*LANES +: LANES] = base + LANES'(k);
      if ((k % PACK) == PACK - 1 || k == n - 1) begin
        ewq.push_back(w); elq.push_back(k == n - 1); erq.push_back(rt);
        w = '0;
      end
    end
    for (int k = 0; k < n; k++) begin
      rx_valid = 1; rx_route = rt; rx_lanes = base + LANES'(k);
      step();
    end
    rx_valid = 0;
    step(); step(); step();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog [%s]: actual timeout expected completion", scen);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    scen = "R11 reset";
    chk("R11 tx_valid", 64'(tx_valid), 64'd0);
    chk("R11 retry_cnt", 64'(retry_cnt), 64'd0);
    chk("R11 rx_word_valid", 64'(rx_word_valid), 64'd0);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk("R11 push_ready", 64'(push_ready), 64'd1);
    compare();

    scen = "R1 R2 fifo order and routes";
    push_msg(6, 5'h13, 16'h1100);
    push_msg(5, 5'h0a, 16'h2200);
    drain();

    scen = "R4 short message padded";
    push_msg(2, 5'h05, 16'h3300);
    push_msg(1, 5'h1f, 16'h4400);
    push_msg(4, 5'h11, 16'h5500);
    drain();

    scen = "R5 nack mid packet";
    push_msg(5, 5'h06, 16'h6600);
    while (!(busy && idx == 2)) step();
    nack = 1; step(); nack = 0;
    scen = "R6 nack on final word";
    while (!(busy && idx == 4)) step();
    nack = 1; step(); nack = 0;
    drain();

    scen = "R7 nack while idle";
    nack = 1; step(); step(); step(); nack = 0;
    step();

    scen = "R8 retry saturation";
    push_msg(3, 5'h09, 16'h7700);
    while (!busy) step();
    nack = 1;
    repeat (RMAX + 5) step();
    nack = 0;
    drain();

    scen = "R9 descriptor slots full";
    nack = 1;
    for (int m = 0; m < DDEPTH; m++) push_msg(1, 5'(m), 16'h8000 + 16'(m));
    push_valid = 1; push_data = 16'hdead; push_last = 1; push_route = 5'h1e;
    step(); step();
    push_valid = 0; push_last = 0;
    nack = 0;
    drain();

    scen = "R9 word slots full";
    nack = 1;
    push_msg(8, 5'h03, 16'h9000);
    push_msg(8, 5'h0c, 16'ha000);
    push_valid = 1; push_data = 16'hbeef; push_last = 1; push_route = 5'h1d;
    step(); step();
    push_valid = 0; push_last = 0;
    nack = 0;
    drain();

    scen = "R10 receive reassembly";
    rx_packet(4, 5'h15, 16'hc000);
    rx_packet(3, 5'h0b, 16'hd000);
    rx_packet(1, 5'h01, 16'he000);
    rx_packet(5, 5'h1a, 16'hf000);
    chk("R10 rx words outstanding", 64'(ewq.size()), 64'd0);

    finish_run();
  end

endmodule